// File: doc/BRIEF.md
# Three-Frame CAN Receive Mailbox FIFO

This block sits between an acceptance-filtered CAN receive path and the register file that software reads. Each accepted frame arrives as four 32-bit words on a single-cycle write strobe: identifier, property/length, first data word and second data word. The block keeps up to three frames and presents the oldest one on four read-word outputs. Software reads those words and then pulses a release strobe, which retires the head frame so that the next one is shown.

Status outputs give a two-bit fill count, a full indication, a frame-pending indication and a sticky overrun flag. Software clears the overrun flag with a write-one-to-clear strobe. A policy input sets what happens when a frame arrives with three frames already stored. One setting drops the arrival. The other replaces the most recently stored frame, so the two older frames keep their places.

Every status and read-word output reflects the state after the clock edge that captured the inputs. A write or a release becomes visible in the cycle after its strobe.

Top module: `can_rx_mbox`

## Requirements
- R1: Frames leave in the order they were accepted, so the first frame written is the first shown on the read words.
- R2: `fill_len` counts stored frames from 0 (empty) to 3 (three frames stored) and never goes past 3.
- R3: `full_flag` is high exactly when three frames are stored.
- R4: A write strobe that arrives while three frames are stored, with no release in the same cycle, sets `ovr_flag`.
- R5: With `drop_on_ovr` = 1, an overrunning frame is discarded, and the three stored frames and `fill_len` = 3 are unchanged.
- R6: With `drop_on_ovr` = 0, an overrunning frame replaces the most recently stored frame, the two older frames keep their order, and `fill_len` stays 3.
- R7: The head frame appears on `rd_id`, `rd_prop`, `rd_data0` and `rd_data1`. A `rel_pulse` while frames are stored removes the head, and the next frame shows in the following cycle.
- R8: `rel_pulse` while empty has no effect, and `fill_len` stays 0.
- R9: A write and a release in the same cycle on a full FIFO act as release-then-store: the new frame becomes the newest, `fill_len` stays 3 and `ovr_flag` is not set.
- R10: `ovr_flag` stays high until an `ovr_clr` pulse, and a new overrun in the same cycle as `ovr_clr` keeps it high. `full_flag` falls in the cycle after a release from full.
- R11: While empty, all four read words are zero. `pending` is high exactly when `fill_len` is nonzero.
- R12: A synchronous `rst` empties the FIFO and clears `ovr_flag`, `full_flag` and `pending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One-cycle strobe: accepted frame present |
| wr_id | input | 32 | Identifier word of incoming frame |
| wr_prop | input | 32 | Property/length word of incoming frame |
| wr_data0 | input | 32 | First data word of incoming frame |
| wr_data1 | input | 32 | Second data word of incoming frame |
| drop_on_ovr | input | 1 | Overrun policy: 1 drops arrival, 0 replaces newest |
| rel_pulse | input | 1 | One-cycle release of the head frame |
| ovr_clr | input | 1 | One-cycle clear of the overrun flag |
| rd_id | output | 32 | Head frame identifier word (zero when empty) |
| rd_prop | output | 32 | Head frame property/length word (zero when empty) |
| rd_data0 | output | 32 | Head frame first data word (zero when empty) |
| rd_data1 | output | 32 | Head frame second data word (zero when empty) |
| fill_len | output | 2 | Number of stored frames, 0 to 3 |
| full_flag | output | 1 | High when three frames are stored |
| ovr_flag | output | 1 | Sticky overrun indication |
| pending | output | 1 | High when at least one frame is stored |

## Verification
The assertions assume that `wr_valid`, `rel_pulse` and `ovr_clr` are sampled cleanly at the rising edge and are known whenever `rst` is low. They also assume that `drop_on_ovr` holds steady during any cycle in which an overrun can occur. The stimulus drives every input on the falling edge, returns each strobe to zero after one cycle, and changes the policy bit only while the FIFO is below full. It reads outputs on the falling edge after the capturing rising edge. Overrun, release from empty, and simultaneous release and write on a full FIFO are each driven as their own scenario, so the assertions cover each case separately.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;
  localparam int WORD_W = 32;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t id;
    word_t prop;
    word_t d0;
    word_t d1;
  } frame_t;

  localparam frame_t FRAME_ZERO = '0;
endpackage

// File: rtl/rxmb_ptr.sv
module rxmb_ptr #(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [PW-1:0] ptr,
  output logic [PW-1:0] prev
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)      ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  // slot written most recently, modulo DEPTH
  always_comb prev = (ptr == '0) ? LAST : ptr - 1'b1;

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (rst)
    ptr <= LAST);
endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
  import rxmb_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  frame_t        wdata,
  input  logic [PW-1:0] raddr,
  output frame_t        rdata
);
  frame_t slots [DEPTH];

  // plain write port with no reset, inferable as distributed RAM
  always_ff @(posedge clk) begin
    if (we) slots[waddr] <= wdata;
  end

  always_comb rdata = slots[raddr];
endmodule

// File: rtl/rxmb_ctrl.sv
module rxmb_ctrl #(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_i,
  input  logic          rel_i,
  input  logic          clr_i,
  input  logic          drop_i,
  input  logic [PW-1:0] wptr_prev,
  input  logic [PW-1:0] wptr,
  output logic          wptr_adv,
  output logic          rptr_adv,
  output logic          we_o,
  output logic [PW-1:0] waddr_o,
  output logic [LW-1:0] count_o,
  output logic          full_o,
  output logic          pend_o,
  output logic          ovr_o
);
  localparam logic [LW-1:0] CAP = LW'(DEPTH);

  logic          pop, at_cap, ovr_evt, store_new, over_wr;
  logic [LW-1:0] cnt_n;

  always_comb begin
    pop       = rel_i && (count_o != '0);
    at_cap    = (count_o == CAP);
    ovr_evt   = wr_i && at_cap && !pop;
    store_new = wr_i && (!at_cap || pop);
    over_wr   = ovr_evt && !drop_i;
    cnt_n     = count_o + LW'(store_new) - LW'(pop);
    wptr_adv  = store_new;
    rptr_adv  = pop;
    we_o      = store_new || over_wr;
    waddr_o   = over_wr ? wptr_prev : wptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_o <= '0;
      full_o  <= 1'b0;
      pend_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else begin
      count_o <= cnt_n;
      full_o  <= (cnt_n == CAP);
      pend_o  <= (cnt_n != '0);
      if (ovr_evt)    ovr_o <= 1'b1;
      else if (clr_i) ovr_o <= 1'b0;
    end
  end

  p_len_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count_o <= CAP);
  p_full_match_r3: assert property (@(posedge clk) disable iff (rst)
    full_o == (count_o == CAP));
  p_ovr_set_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_i && full_o && !rel_i) |=> ovr_o);
  p_ovr_len_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_i && full_o && !rel_i) |=> (count_o == CAP));
  p_empty_rel_r8: assert property (@(posedge clk) disable iff (rst)
    (!pend_o && rel_i && !wr_i) |=> (count_o == '0));
  p_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_i && rel_i && full_o && !ovr_o) |=> (full_o && !ovr_o));
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (ovr_o && !clr_i) |=> ovr_o);
  p_pend_r11: assert property (@(posedge clk) disable iff (rst)
    pend_o == (count_o != '0));
endmodule

// File: rtl/can_rx_mbox.sv
module can_rx_mbox
  import rxmb_pkg::*;
#(
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [31:0]   wr_id,
  input  logic [31:0]   wr_prop,
  input  logic [31:0]   wr_data0,
  input  logic [31:0]   wr_data1,
  input  logic          drop_on_ovr,
  input  logic          rel_pulse,
  input  logic          ovr_clr,
  output logic [31:0]   rd_id,
  output logic [31:0]   rd_prop,
  output logic [31:0]   rd_data0,
  output logic [31:0]   rd_data1,
  output logic [LW-1:0] fill_len,
  output logic          full_flag,
  output logic          ovr_flag,
  output logic          pending
);
  logic          w_adv, r_adv, we;
  logic [PW-1:0] wptr, wprev, rptr, rprev, waddr;
  frame_t        wframe, head;

  always_comb begin
    wframe.id   = wr_id;
    wframe.prop = wr_prop;
    wframe.d0   = wr_data0;
    wframe.d1   = wr_data1;
  end

  rxmb_ptr #(.DEPTH(DEPTH)) u_wptr (
    .clk(clk), .rst(rst), .adv(w_adv), .ptr(wptr), .prev(wprev));

  rxmb_ptr #(.DEPTH(DEPTH)) u_rptr (
    .clk(clk), .rst(rst), .adv(r_adv), .ptr(rptr), .prev(rprev));

  rxmb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_i(wr_valid), .rel_i(rel_pulse),
    .clr_i(ovr_clr), .drop_i(drop_on_ovr), .wptr_prev(wprev),
    .wptr(wptr), .wptr_adv(w_adv), .rptr_adv(r_adv), .we_o(we),
    .waddr_o(waddr), .count_o(fill_len), .full_o(full_flag),
    .pend_o(pending), .ovr_o(ovr_flag));

  rxmb_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wframe),
    .raddr(rptr), .rdata(head));

  // empty FIFO reads as zero words
  always_comb begin
    rd_id    = pending ? head.id   : '0;
    rd_prop  = pending ? head.prop : '0;
    rd_data0 = pending ? head.d0   : '0;
    rd_data1 = pending ? head.d1   : '0;
  end

  p_empty_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !pending |-> (rd_id == '0 && rd_prop == '0 && rd_data0 == '0 && rd_data1 == '0));
  p_head_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (pending && !rel_pulse) |=> $stable(rd_id));
endmodule

// File: tb/sim_can_rx_mbox.sv
module sim_can_rx_mbox;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0, drop_on_ovr = 1'b1, rel_pulse = 1'b0, ovr_clr = 1'b0;
  logic [31:0] wr_id = '0, wr_prop = '0, wr_data0 = '0, wr_data1 = '0;
  logic [31:0] rd_id, rd_prop, rd_data0, rd_data1;
  logic [1:0]  fill_len;
  logic        full_flag, ovr_flag, pending;
  int          n_cmp = 0, n_bad = 0, cyc = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  can_rx_mbox u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected < 20000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [127:0] mk(input int k);
    return {32'hA000_0000 + k, 32'h0000_0800 + (k << 16), 32'hD000_0000 + k, 32'hE000_0000 + k};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input int k, input bit r, input bit c);
    @(negedge clk);
    {wr_id, wr_prop, wr_data0, wr_data1} = mk(k);
    wr_valid = w; rel_pulse = r; ovr_clr = c;
    @(negedge clk);
    wr_valid = 1'b0; rel_pulse = 1'b0; ovr_clr = 1'b0;
  endtask

  task automatic push(input int k);  step(1'b1, k, 1'b0, 1'b0); endtask
  task automatic pop();              step(1'b0, 0, 1'b1, 1'b0); endtask

  task automatic head(input string req, input int k);
    chk(req, {rd_id, rd_prop, rd_data0, rd_data1}, mk(k));
  endtask

  task automatic stat(input string req, input int len, input bit f, input bit o);
    chk(req, {fill_len, full_flag, ovr_flag, pending}, {2'(len), f, o, len != 0});
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    stat("R12 reset status", 0, 0, 0);
    chk("R11 empty words zero", {rd_id, rd_prop, rd_data0, rd_data1}, '0);
  endtask

  task automatic t_order();
    push(1); head("R7 head first", 1); stat("R11 pending one", 1, 0, 0);
    push(2); head("R1 head stays oldest", 1); stat("R2 len two", 2, 0, 0);
    pop();   head("R1 second after release", 2);
    pop();   stat("R7 drained", 0, 0, 0);
    chk("R11 zero after drain", {rd_id, rd_prop, rd_data0, rd_data1}, '0);
  endtask

  task automatic t_empty_rel();
    pop(); stat("R8 release empty", 0, 0, 0);
    push(5); head("R8 next frame ok", 5); pop();
  endtask

  task automatic t_full();
    push(10); push(11); push(12);
    stat("R3 full at three", 3, 1, 0);
    pop(); stat("R10 full clears", 2, 0, 0); head("R1 after pop", 11);
    pop(); pop(); stat("R2 empty again", 0, 0, 0);
  endtask

  task automatic t_drop();
    drop_on_ovr = 1'b1;
    push(20); push(21); push(22); push(23);
    stat("R4 overrun set", 3, 1, 1);
    repeat (3) @(negedge clk);
    stat("R10 sticky", 3, 1, 1);
    head("R5 head kept", 20); pop();
    head("R5 second kept", 21); pop();
    head("R5 newest kept", 22); pop();
    stat("R5 empty after", 0, 0, 1);
    step(1'b0, 0, 1'b0, 1'b1);
    stat("R10 cleared", 0, 0, 0);
  endtask

  task automatic t_overwrite();
    drop_on_ovr = 1'b0;
    push(30); push(31); push(32); push(33);
    stat("R6 len stays three", 3, 1, 1);
    head("R6 oldest", 30); pop();
    head("R6 middle", 31); pop();
    head("R6 replaced newest", 33); pop();
    step(1'b0, 0, 1'b0, 1'b1);
    drop_on_ovr = 1'b1;
  endtask

  task automatic t_swap();
    push(40); push(41); push(42);
    step(1'b1, 43, 1'b1, 1'b0);
    stat("R9 no overrun", 3, 1, 0);
    head("R9 head advanced", 41); pop();
    head("R9 order", 42); pop();
    head("R9 stored new", 43); pop();
  endtask

  task automatic t_set_wins();
    push(50); push(51); push(52);
    step(1'b1, 53, 1'b0, 1'b0);
    step(1'b1, 54, 1'b0, 1'b1);
    stat("R10 set beats clear", 3, 1, 1);
    push(60);  // still full: drop mode, flag stays set
    do_reset();
    stat("R12 mid-run reset", 0, 0, 0);
  endtask

  initial begin
    t_reset();
    t_order();
    t_empty_rel();
    t_full();
    t_drop();
    t_overwrite();
    t_swap();
    t_set_wins();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule